// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the 32-bit data-processing stage of an integer pipeline. Each cycle it takes two operands, a 5-bit operation code, a flag-update enable, the incoming N, Z, C and V condition flags and the carry-out produced by an external barrel shifter. It returns the operation result, a destination write enable and the next value of each of the four flags.

The operation set covers bitwise logic (AND, XOR, OR, OR-with-inverse, AND-with-inverse, move, move-inverse), two's-complement arithmetic (add, subtract, reverse subtract and the three forms that fold in the incoming carry), flag-only comparisons and tests, an insert of a halfword into the upper half of a word, and a word-aligned program-counter-relative address calculation. The operand shifter, register file access and conditional execution live outside the block; the shifter's carry-out arrives on its own input and is what logical operations load into C.

All outputs are registered: the values for an input set applied before a rising clock edge appear right after that edge. A synchronous active-high reset clears every output.

Top module: `int_alu_flags`

## Requirements
- R1: When flags update, N equals bit 31 of the operation value and Z is 1 exactly when all 32 bits of that value are zero.
- R2: Add (opcode 4) computes A+B and add-with-carry (5) computes A+B+C_in; when flags update, C is the carry out of bit 31 and V the signed overflow of that sum.
- R3: Subtract (2) computes A+~B+1 and subtract-with-carry (6) computes A+~B+C_in; C is the carry out of that sum (1 means no borrow) and V its signed overflow.
- R4: Reverse subtract (3) computes B+~A+1 and its carry form (7) computes B+~A+C_in, with C and V taken from that sum.
- R5: Logical operations AND (0), XOR (1), OR (12), OR-inverse A|~B (13), move B (14), AND-inverse A&~B (15) and move-inverse ~B (16) write the result, load C from the shifter carry input and leave V equal to the incoming V.
- R6: Test A&B (8), test-equivalence A^B (9), compare A+~B+1 (10) and compare-negative A+B (11) never assert the write enable and update the flags whether or not the flag-update enable is set; test forms take C from the shifter and keep V, compare forms take C and V from the sum.
- R7: Halfword insert (17) returns B[15:0] in bits 31:16 and A[15:0] in bits 15:0, with flags handled as for logical operations.
- R8: Address form (18) returns (A with bits 1:0 cleared) plus B when the direction input is 1 and minus B when it is 0, with flags handled as for logical operations.
- R9: When the flag-update enable is 0 and the opcode is not one of 8 to 11, all four flag outputs equal the incoming flags.
- R10: Opcodes 19 to 31 produce a zero result, a low write enable and unchanged flags.
- R11: Outputs change one clock edge after the inputs are applied; while reset is high the result, write enable and all flags are zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 5 | Operation select, encoding as in the requirements |
| op_a | input | 32 | First operand (program counter for the address form) |
| op_b | input | 32 | Second operand, already shifted |
| set_flags | input | 1 | Flag-update enable |
| addr_up | input | 1 | Address form direction: 1 adds, 0 subtracts |
| shift_carry | input | 1 | Carry-out of the external shifter |
| flag_n_in | input | 1 | Incoming N |
| flag_z_in | input | 1 | Incoming Z |
| flag_c_in | input | 1 | Incoming C |
| flag_v_in | input | 1 | Incoming V |
| result | output | 32 | Registered operation result |
| wr_en | output | 1 | Registered destination write enable |
| flag_n | output | 1 | Registered next N |
| flag_z | output | 1 | Registered next Z |
| flag_c | output | 1 | Registered next C |
| flag_v | output | 1 | Registered next V |

## Verification
Every output of this block, result, write enable and all four flags alike, is due at the first rising edge after the inputs are set, because the only register on any path is the output stage. The bench therefore drives a new input set on a falling edge, waits for the next rising edge and samples one time unit later, so each comparison sees exactly the cycle that followed its own stimulus. Held flags, the compare forms that ignore the enable and the unused opcodes are checked on the same one-cycle schedule, and reset is checked at the edge after it is raised.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  localparam int OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_AND  = 5'd0,  OP_EOR  = 5'd1,  OP_SUB  = 5'd2,  OP_RSB  = 5'd3,
    OP_ADD  = 5'd4,  OP_ADC  = 5'd5,  OP_SBC  = 5'd6,  OP_RSC  = 5'd7,
    OP_TST  = 5'd8,  OP_TEQ  = 5'd9,  OP_CMP  = 5'd10, OP_CMN  = 5'd11,
    OP_ORR  = 5'd12, OP_ORN  = 5'd13, OP_MOV  = 5'd14, OP_BIC  = 5'd15,
    OP_MVN  = 5'd16, OP_INS  = 5'd17, OP_ADDR = 5'd18
  } alu_op_e;

  // adder first-operand source
  typedef enum logic [1:0] {XS_A, XS_B, XS_PC} xsel_e;
  // adder second-operand source
  typedef enum logic [1:0] {YS_B, YS_NB, YS_NA, YS_OFF} ysel_e;
  // adder carry-in source
  typedef enum logic [1:0] {CI_ZERO, CI_ONE, CI_FLAG, CI_DIR} csel_e;
  // bitwise function
  typedef enum logic [2:0] {
    LF_AND, LF_EOR, LF_ORR, LF_ORN, LF_BIC, LF_MOV, LF_MVN, LF_INS
  } lfn_e;

  typedef struct packed {
    logic  legal;
    logic  writes;
    logic  always_flags;
    logic  take_sum;
    logic  arith_cv;
    xsel_e xs;
    ysel_e ys;
    csel_e cs;
    lfn_e  lf;
  } dec_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_flags_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);

  always_comb begin
    dec = '{legal: 1'b1, writes: 1'b1, always_flags: 1'b0, take_sum: 1'b0,
            arith_cv: 1'b0, xs: XS_A, ys: YS_B, cs: CI_ZERO, lf: LF_AND};
    case (opcode)
      OP_AND:  dec.lf = LF_AND;
      OP_EOR:  dec.lf = LF_EOR;
      OP_ORR:  dec.lf = LF_ORR;
      OP_ORN:  dec.lf = LF_ORN;
      OP_BIC:  dec.lf = LF_BIC;
      OP_MOV:  dec.lf = LF_MOV;
      OP_MVN:  dec.lf = LF_MVN;
      OP_INS:  dec.lf = LF_INS;
      OP_TST: begin dec.lf = LF_AND; dec.writes = 1'b0; dec.always_flags = 1'b1; end
      OP_TEQ: begin dec.lf = LF_EOR; dec.writes = 1'b0; dec.always_flags = 1'b1; end
      OP_ADD: begin dec.take_sum = 1'b1; dec.arith_cv = 1'b1; end
      OP_ADC: begin dec.take_sum = 1'b1; dec.arith_cv = 1'b1; dec.cs = CI_FLAG; end
      OP_SUB: begin dec.take_sum = 1'b1; dec.arith_cv = 1'b1; dec.ys = YS_NB; dec.cs = CI_ONE; end
      OP_SBC: begin dec.take_sum = 1'b1; dec.arith_cv = 1'b1; dec.ys = YS_NB; dec.cs = CI_FLAG; end
      OP_RSB: begin
        dec.take_sum = 1'b1; dec.arith_cv = 1'b1;
        dec.xs = XS_B; dec.ys = YS_NA; dec.cs = CI_ONE;
      end
      OP_RSC: begin
        dec.take_sum = 1'b1; dec.arith_cv = 1'b1;
        dec.xs = XS_B; dec.ys = YS_NA; dec.cs = CI_FLAG;
      end
      OP_CMP: begin
        dec.take_sum = 1'b1; dec.arith_cv = 1'b1; dec.ys = YS_NB; dec.cs = CI_ONE;
        dec.writes = 1'b0; dec.always_flags = 1'b1;
      end
      OP_CMN: begin
        dec.take_sum = 1'b1; dec.arith_cv = 1'b1;
        dec.writes = 1'b0; dec.always_flags = 1'b1;
      end
      OP_ADDR: begin
        dec.take_sum = 1'b1; dec.xs = XS_PC; dec.ys = YS_OFF; dec.cs = CI_DIR;
      end
      default: begin dec.legal = 1'b0; dec.writes = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_flags_pkg::*;
#(
  parameter int W = 32
) (
  input  lfn_e         fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam int HALF = W / 2;

  always_comb begin
    case (fn)
      LF_AND:  y = a & b;
      LF_EOR:  y = a ^ b;
      LF_ORR:  y = a | b;
      LF_ORN:  y = a | ~b;
      LF_BIC:  y = a & ~b;
      LF_MOV:  y = b;
      LF_MVN:  y = ~b;
      LF_INS:  y = {b[HALF-1:0], a[HALF-1:0]};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
  end

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import alu_flags_pkg::*;
#(
  parameter int W     = 32,
  parameter int ALIGN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic             set_flags,
  input  logic             addr_up,
  input  logic             shift_carry,
  input  logic             flag_n_in,
  input  logic             flag_z_in,
  input  logic             flag_c_in,
  input  logic             flag_v_in,
  output logic [W-1:0]     result,
  output logic             wr_en,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);

  localparam int MSB = W - 1;
  localparam logic [W-1:0] ALIGN_MASK = ~((W'(1) << ALIGN) - W'(1));

  dec_t         dec;
  logic [W-1:0] add_x, add_y, add_sum, lu_res, op_val;
  logic         add_cin, add_cout, add_ovf, upd;
  logic [W-1:0] res_d;
  logic         we_d, n_d, z_d, c_d, v_d;

  alu_decode u_dec (
    .opcode (opcode),
    .dec    (dec)
  );

  always_comb begin
    case (dec.xs)
      XS_B:    add_x = op_b;
      XS_PC:   add_x = op_a & ALIGN_MASK;
      default: add_x = op_a;
    endcase
    case (dec.ys)
      YS_NB:   add_y = ~op_b;
      YS_NA:   add_y = ~op_a;
      YS_OFF:  add_y = addr_up ? op_b : ~op_b;
      default: add_y = op_b;
    endcase
    case (dec.cs)
      CI_ONE:  add_cin = 1'b1;
      CI_FLAG: add_cin = flag_c_in;
      CI_DIR:  add_cin = ~addr_up;
      default: add_cin = 1'b0;
    endcase
  end

  alu_addsub #(.W(W)) u_add (
    .x    (add_x),
    .y    (add_y),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  alu_logic_unit #(.W(W)) u_lu (
    .fn (dec.lf),
    .a  (op_a),
    .b  (op_b),
    .y  (lu_res)
  );

  always_comb begin
    op_val = dec.take_sum ? add_sum : lu_res;
    upd    = dec.legal && (set_flags || dec.always_flags);
    res_d  = dec.legal ? op_val : '0;
    we_d   = dec.writes;
    n_d    = flag_n_in;
    z_d    = flag_z_in;
    c_d    = flag_c_in;
    v_d    = flag_v_in;
    if (upd) begin
      n_d = op_val[MSB];
      z_d = (op_val == '0);
      c_d = dec.arith_cv ? add_cout : shift_carry;
      v_d = dec.arith_cv ? add_ovf : flag_v_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      wr_en  <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else begin
      result <= res_d;
      wr_en  <= we_d;
      flag_n <= n_d;
      flag_z <= z_d;
      flag_c <= c_d;
      flag_v <= v_d;
    end
  end

endmodule

// File: rtl/int_alu_flags_chk.sv
module int_alu_flags_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [4:0]   opcode,
  input logic         set_flags,
  input logic         flag_n_in,
  input logic         flag_z_in,
  input logic         flag_c_in,
  input logic         flag_v_in,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_v
);

  logic is_cmp, is_logic, is_free;
  always_comb begin
    is_cmp   = (opcode >= 5'd8) && (opcode <= 5'd11);
    is_free  = (opcode >= 5'd19);
    is_logic = (opcode <= 5'd1) || ((opcode >= 5'd12) && (opcode <= 5'd18));
  end

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_cmp)) |-> !wr_en); // R6

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(set_flags) && !$past(is_cmp)) |->
      ({flag_n, flag_z, flag_c, flag_v} ==
       $past({flag_n_in, flag_z_in, flag_c_in, flag_v_in}))); // R9

  AST_Z_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(set_flags) && !$past(is_cmp) && !$past(is_free)) |->
      (flag_z == (result == '0)) && (flag_n == result[W-1])); // R1

  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_logic)) |-> (flag_v == $past(flag_v_in))); // R5

  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_free)) |-> (result == '0) && !wr_en); // R10

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (result == '0) && !wr_en && !flag_n && !flag_z && !flag_c && !flag_v); // R11

endmodule

bind int_alu_flags int_alu_flags_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .opcode    (opcode),
  .set_flags (set_flags),
  .flag_n_in (flag_n_in),
  .flag_z_in (flag_z_in),
  .flag_c_in (flag_c_in),
  .flag_v_in (flag_v_in),
  .result    (result),
  .wr_en     (wr_en),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .flag_v    (flag_v)
);

// File: tb/int_alu_flags_tb.sv
module int_alu_flags_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  opcode = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        set_flags = 1'b0, addr_up = 1'b1, shift_carry = 1'b0;
  logic        fn_i = 1'b0, fz_i = 1'b0, fc_i = 1'b0, fv_i = 1'b0;
  logic [31:0] result;
  logic        wr_en, flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  int_alu_flags u_dut (
    .clk (clk), .rst (rst), .opcode (opcode), .op_a (op_a), .op_b (op_b),
    .set_flags (set_flags), .addr_up (addr_up), .shift_carry (shift_carry),
    .flag_n_in (fn_i), .flag_z_in (fz_i), .flag_c_in (fc_i), .flag_v_in (fv_i),
    .result (result), .wr_en (wr_en), .flag_n (flag_n), .flag_z (flag_z),
    .flag_c (flag_c), .flag_v (flag_v)
  );

  // directed vector table: opcode, A, B, expected result, expected NZCV
  // (flag update on, incoming flags 0000, shifter carry 0, direction add)
  localparam int NV = 12;
  localparam logic [4:0]  T_OP [NV] = '{5'd4, 5'd4, 5'd2, 5'd2, 5'd3, 5'd0,
                                        5'd1, 5'd17, 5'd18, 5'd16, 5'd13, 5'd2};
  localparam logic [31:0] T_A  [NV] = '{32'hFFFFFFFF, 32'h7FFFFFFF, 32'd5, 32'd3,
                                        32'd3, 32'hF0F0F0F0, 32'h12345678, 32'hAAAA1234,
                                        32'h00001003, 32'h0, 32'h0, 32'h80000000};
  localparam logic [31:0] T_B  [NV] = '{32'd1, 32'd1, 32'd3, 32'd5,
                                        32'd5, 32'h0FF00000, 32'h12345678, 32'h0000BEEF,
                                        32'h10, 32'h0, 32'hFFFFFFFF, 32'd1};
  localparam logic [31:0] T_R  [NV] = '{32'h0, 32'h80000000, 32'd2, 32'hFFFFFFFE,
                                        32'd2, 32'h00F00000, 32'h0, 32'hBEEF1234,
                                        32'h00001010, 32'hFFFFFFFF, 32'h0, 32'h7FFFFFFF};
  localparam logic [3:0]  T_F  [NV] = '{4'b0110, 4'b1001, 4'b0010, 4'b1000,
                                        4'b0010, 4'b0000, 4'b0100, 4'b1000,
                                        4'b0000, 4'b1000, 4'b0100, 4'b0011};

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd4, 5'd5: return "R2";
      5'd2, 5'd6: return "R3";
      5'd3, 5'd7: return "R4";
      5'd8, 5'd9, 5'd10, 5'd11: return "R6";
      5'd17: return "R7";
      5'd18: return "R8";
      default: return (op >= 5'd19) ? "R10" : "R5";
    endcase
  endfunction

  // reference model from the requirements: {result, we, N, Z, C, V}
  function automatic logic [36:0] model(input logic [4:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic sf, input logic up, input logic sc,
      input logic [3:0] fin);
    logic [32:0] s;
    logic [31:0] x, y, r;
    logic cin, arith, we, legal, forced, c, v;
    arith = 1'b0; we = 1'b1; legal = 1'b1; forced = 1'b0;
    x = a; y = b; cin = 1'b0; r = '0;
    case (op)
      5'd0: r = a & b;   5'd1: r = a ^ b;   5'd12: r = a | b;  5'd13: r = a | ~b;
      5'd14: r = b;      5'd15: r = a & ~b; 5'd16: r = ~b;
      5'd17: r = {b[15:0], a[15:0]};
      5'd18: r = up ? ((a & ~32'd3) + b) : ((a & ~32'd3) - b);
      5'd8: begin r = a & b; we = 1'b0; forced = 1'b1; end
      5'd9: begin r = a ^ b; we = 1'b0; forced = 1'b1; end
      5'd4: begin arith = 1'b1; end
      5'd5: begin arith = 1'b1; cin = fin[1]; end
      5'd2: begin arith = 1'b1; y = ~b; cin = 1'b1; end
      5'd6: begin arith = 1'b1; y = ~b; cin = fin[1]; end
      5'd3: begin arith = 1'b1; x = b; y = ~a; cin = 1'b1; end
      5'd7: begin arith = 1'b1; x = b; y = ~a; cin = fin[1]; end
      5'd10: begin arith = 1'b1; y = ~b; cin = 1'b1; we = 1'b0; forced = 1'b1; end
      5'd11: begin arith = 1'b1; we = 1'b0; forced = 1'b1; end
      default: begin legal = 1'b0; we = 1'b0; end
    endcase
    s = {1'b0, x} + {1'b0, y} + {32'd0, cin};
    if (arith) r = s[31:0];
    c = arith ? s[32] : sc;
    v = arith ? ((x[31] == y[31]) && (s[31] != x[31])) : fin[0];
    if (legal && (sf || forced))
      return {r, we, r[31], (r == 32'd0), c, v};
    return {(legal ? r : 32'd0), we, fin};
  endfunction

  task automatic step(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
      input logic sf, input logic up, input logic sc, input logic [3:0] fin);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; set_flags = sf; addr_up = up;
    shift_carry = sc; {fn_i, fz_i, fc_i, fv_i} = fin;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [36:0] exp);
    logic [36:0] got;
    got = {result, wr_en, flag_n, flag_z, flag_c, flag_v};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s op=%0d got res=%h we=%b nzcv=%b exp res=%h we=%b nzcv=%b",
               tag, opcode, got[36:5], got[4], got[3:0], exp[36:5], exp[4], exp[3:0]);
    end
  endtask

  task automatic run_model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
      input logic sf, input logic up, input logic sc, input logic [3:0] fin);
    step(op, a, b, sf, up, sc, fin);
    expect_out(tag_of(op), model(op, a, b, sf, up, sc, fin));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11: reset clears every output, even with live inputs
    step(5'd16, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1, 4'b1111);
    step(5'd16, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1, 4'b1111);
    expect_out("R11", 37'd0);
    @(negedge clk); rst = 1'b0;

    // table walk (R1 flags on every vector)
    for (int i = 0; i < NV; i++) begin
      step(T_OP[i], T_A[i], T_B[i], 1'b1, 1'b1, 1'b0, 4'b0000);
      expect_out($sformatf("R1/%s vec%0d", tag_of(T_OP[i]), i), {T_R[i], 1'b1, T_F[i]});
    end

    // R11: result appears exactly one edge after the inputs
    step(5'd14, 32'h0, 32'h5A5A5A5A, 1'b0, 1'b1, 1'b0, 4'b0000);
    expect_out("R11 latency", {32'h5A5A5A5A, 1'b1, 4'b0000});

    // R2: add with carry-in 1 and max operands
    step(5'd5, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 4'b0010);
    expect_out("R2 adc", {32'hFFFFFFFF, 1'b1, 4'b1010});
    // R3: subtract with carry 0 takes one extra
    step(5'd6, 32'd10, 32'd3, 1'b1, 1'b1, 1'b0, 4'b0000);
    expect_out("R3 sbc", {32'd6, 1'b1, 4'b0010});
    // R4: reverse subtract with carry 0
    step(5'd7, 32'd3, 32'd10, 1'b1, 1'b1, 1'b0, 4'b0000);
    expect_out("R4 rsc", {32'd6, 1'b1, 4'b0010});
    // R5: logic takes C from shifter, keeps V=1
    step(5'd12, 32'h0, 32'h1, 1'b1, 1'b1, 1'b1, 4'b0001);
    expect_out("R5 orr", {32'h1, 1'b1, 4'b0011});
    // R6: compare with flag enable low still updates, no write
    step(5'd10, 32'd7, 32'd7, 1'b0, 1'b1, 1'b0, 4'b1001);
    expect_out("R6 cmp", {32'd0, 1'b0, 4'b0110});
    // R6: test with flag enable low, V kept
    step(5'd8, 32'hF0000000, 32'h80000000, 1'b0, 1'b1, 1'b1, 4'b0001);
    expect_out("R6 tst", {32'h80000000, 1'b0, 4'b1011});
    // R8: address form subtracting
    step(5'd18, 32'h00002002, 32'h4, 1'b0, 1'b0, 1'b0, 4'b0000);
    expect_out("R8 sub", {32'h00001FFC, 1'b1, 4'b0000});
    // R9: flag enable low leaves flags as they came in
    step(5'd4, 32'hFFFFFFFF, 32'd1, 1'b0, 1'b1, 1'b1, 4'b1010);
    expect_out("R9 hold", {32'h0, 1'b1, 4'b1010});
    // R10: unused opcode
    step(5'd31, 32'h12345678, 32'h9ABCDEF0, 1'b1, 1'b1, 1'b1, 4'b0101);
    expect_out("R10 unused", {32'h0, 1'b0, 4'b0101});

    // every opcode against the reference model with random values
    for (int k = 0; k < 960; k++) begin
      logic [31:0] ra, rb;
      logic [4:0] rop;
      rop = 5'(k % 32);
      ra = $urandom;
      rb = (k % 5 == 0) ? ~ra : $urandom;
      run_model(rop, ra, rb, 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom));
    end

    // R11: reset raised mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    expect_out("R11 rerst", 37'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule